// File: doc/BRIEF.md
# APB UART Register Interface

This block is the register front end of a memory-mapped UART. It sits on an APB slave port and has three live registers: a data register, a status register and a control register. Software writes a byte to the data register to send it. It reads the data register to take the oldest byte out of a receive FIFO. The bit-level serial shifter is a separate block. Here it is replaced by two byte streams: an incoming stream with valid/ready that fills the FIFO, and an outgoing byte with valid/ready that carries each transmitted byte.

The control register holds a 13-bit field. Its low four bits take effect in this block: receive enable, transmit enable, receive interrupt enable and transmit interrupt enable. A read of the control register also returns a constant FIFO-available flag in bit 31. The status register reports the fill state of the receive FIFO. Its transmit-side flags are fixed at empty, because no transmit queue exists here. A single interrupt line carries a one-cycle pulse for each stored byte and for each completed send, and each of the two directions has its own enable.

Top module: `uart_apb_regs`

## Requirements
- R1: After reset the status register reads 0x0000_0006 and the control register reads 0x8000_0000 (control field zero, bit 31 = FIFO-available flag = 1). The receive FIFO is empty, `irq` is low and `rx_ready` is high.
- R2: Every APB access completes in its access phase (`psel` and `penable` both high), with `pready` = 1 and `pslverr` = 0. A setup-phase cycle (`psel` high, `penable` low) changes no state.
- R3: A byte accepted on the receive input (`rx_valid` and `rx_ready` at a clock edge) is stored only while control bit 0 (receive enable) is 1. Otherwise it is discarded, and the FIFO level and status stay unchanged.
- R4: A read access at offset 0x00 returns the oldest stored byte in `prdata[7:0]`, with the upper bits zero, and removes it. Bytes come out in arrival order.
- R5: A data read from an empty FIFO returns 0 and removes nothing. Status bit 0 (data ready) is 1 exactly while the FIFO holds at least one byte.
- R6: Offset 0x03 acts exactly like offset 0x00, for both reads and writes.
- R7: A write access at offset 0x00 or 0x03 drives `tx_valid` high in that access cycle, with `tx_data` = `pwdata[7:0]`, only while control bit 1 (transmit enable) is 1. The send completes only if `tx_ready` is high in that same cycle.
- R8: `irq` is high for exactly one cycle, the cycle after a byte is stored while control bit 2 is 1, or after a completed send while control bit 3 is 1. At no other time is it high.
- R9: Writes to the status register at offset 0x04 are ignored. A write to the control register at offset 0x08 replaces the whole control field with `pwdata[12:0]`, and bits 30:13 read back as zero.
- R10: Offset 0x0C and every other unmapped offset read as zero and ignore writes. Only address bits 7:0 are decoded.
- R11: Status bit 8 is 1 while the FIFO level is at least RX_DEPTH/2. Status bit 10 is 1 while the level equals RX_DEPTH. `rx_ready` is low while the FIFO is full, so no byte is lost. Status bits 1 and 2 are always 1, and all other status bits are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB enable, marks the access phase |
| pwrite | input | 1 | APB write (1) or read (0) |
| paddr | input | ADDR_W | APB byte address, bits 7:0 decoded |
| pwdata | input | 32 | APB write data |
| prdata | output | 32 | APB read data, valid in the access phase |
| pready | output | 1 | Always 1 (single-cycle access) |
| pslverr | output | 1 | Always 0 |
| rx_valid | input | 1 | Incoming byte present |
| rx_data | input | BYTE_W | Incoming byte |
| rx_ready | output | 1 | Receive FIFO not full |
| tx_valid | output | 1 | Outgoing byte present |
| tx_data | output | BYTE_W | Outgoing byte |
| tx_ready | input | 1 | Sink accepts the outgoing byte |
| irq | output | 1 | Interrupt pulse |

## Verification
The assertions assume well-formed APB traffic: an access phase always follows a setup phase at the same address and direction, and `penable` is never high without `psel`. They also assume that `rx_valid`, `rx_data` and `tx_ready` change only between clock edges. The stimulus meets these assumptions by changing every input on the falling edge. Each access is built as one setup cycle followed by one access cycle, and the bench holds `rx_valid` for exactly one cycle per byte. Because it samples `rx_ready` in that cycle, it knows whether the byte was taken.

// File: rtl/uart_regs_pkg.sv
package uart_regs_pkg;

  localparam int CTRL_W = 13;

  // control bits this block acts on
  localparam int CB_RX_EN = 0;
  localparam int CB_TX_EN = 1;
  localparam int CB_RX_IE = 2;
  localparam int CB_TX_IE = 3;

  // status bit positions
  localparam int SB_DREADY       = 0;
  localparam int SB_TSHIFT_EMPTY = 1;
  localparam int SB_TQUEUE_EMPTY = 2;
  localparam int SB_RX_HALF      = 8;
  localparam int SB_RX_FULL      = 10;

  localparam logic [7:0] OFS_DATA      = 8'h00;
  localparam logic [7:0] OFS_DATA_BYTE = 8'h03;
  localparam logic [7:0] OFS_STATUS    = 8'h04;
  localparam logic [7:0] OFS_CONTROL   = 8'h08;

  typedef enum logic [1:0] {
    SEL_DATA,
    SEL_STAT,
    SEL_CTRL,
    SEL_ZERO
  } reg_sel_e;

  // offset decode; the scaler and everything unmapped fall into SEL_ZERO
  function automatic reg_sel_e decode_offset(logic [7:0] ofs);
    reg_sel_e s;
    case (ofs)
      OFS_DATA, OFS_DATA_BYTE: s = SEL_DATA;
      OFS_STATUS:              s = SEL_STAT;
      OFS_CONTROL:             s = SEL_CTRL;
      default:                 s = SEL_ZERO;
    endcase
    return s;
  endfunction

  function automatic logic [31:0] status_word(int unsigned level, int unsigned depth);
    logic [31:0] s;
    s = '0;
    s[SB_DREADY]       = (level != 0);
    s[SB_TSHIFT_EMPTY] = 1'b1;
    s[SB_TQUEUE_EMPTY] = 1'b1;
    s[SB_RX_HALF]      = (level >= depth / 2);
    s[SB_RX_FULL]      = (level == depth);
    return s;
  endfunction

  function automatic logic [31:0] control_word(logic [CTRL_W-1:0] c, logic avail);
    return {avail, {(31 - CTRL_W){1'b0}}, c};
  endfunction

endpackage

// File: rtl/uart_rx_fifo.sv
module uart_rx_fifo #(
  parameter int DEPTH = 16,
  parameter int W     = 8,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [W-1:0]     din,
  input  logic             pop,
  output logic [W-1:0]     dout,
  output logic [CNT_W-1:0] level,
  output logic             full,
  output logic             empty
);

  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [CNT_W-1:0] level_q;

  function automatic logic [PTR_W-1:0] bump(logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  assign level = level_q;
  assign full  = (level_q == CNT_W'(DEPTH));
  assign empty = (level_q == '0);
  assign dout  = empty ? '0 : mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr  <= '0;
      rd_ptr  <= '0;
      level_q <= '0;
    end else begin
      if (push) wr_ptr <= bump(wr_ptr);
      if (pop)  rd_ptr <= bump(rd_ptr);
      level_q <= level_q + CNT_W'(push) - CNT_W'(pop);
    end
  end

  assert_no_overflow_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (level_q <= CNT_W'(DEPTH)) && !(push && full && !pop));

  assert_no_underflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);

  assert_pop_shrinks_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !push) |=> level_q == $past(level_q) - CNT_W'(1));

endmodule

// File: rtl/uart_ctrl_reg.sv
module uart_ctrl_reg #(
  parameter int W = 13
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] ctrl_q
);

  always_ff @(posedge clk) begin
    if (!rst_n)     ctrl_q <= '0;
    else if (wr_en) ctrl_q <= wdata;
  end

  assert_ctrl_replace_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> ctrl_q == $past(wdata));

  assert_ctrl_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(ctrl_q));

endmodule

// File: rtl/uart_irq_gen.sv
module uart_irq_gen (
  input  logic clk,
  input  logic rst_n,
  input  logic rx_evt,
  input  logic tx_evt,
  input  logic rx_ie,
  input  logic tx_ie,
  output logic irq
);

  logic rx_fire, tx_fire;
  assign rx_fire = rx_evt && rx_ie;
  assign tx_fire = tx_evt && tx_ie;

  always_ff @(posedge clk) begin
    if (!rst_n) irq <= 1'b0;
    else        irq <= rx_fire || tx_fire;
  end

  assert_rx_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rx_fire |=> irq);

  assert_tx_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    tx_fire |=> irq);

  assert_irq_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!rx_fire && !tx_fire) |=> !irq);

endmodule

// File: rtl/uart_apb_regs.sv
module uart_apb_regs
  import uart_regs_pkg::*;
#(
  parameter int   RX_DEPTH   = 16,
  parameter int   ADDR_W     = 8,
  parameter int   BYTE_W     = 8,
  parameter logic FIFO_AVAIL = 1'b1,
  localparam int  CNT_W      = $clog2(RX_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [31:0]       pwdata,
  output logic [31:0]       prdata,
  output logic              pready,
  output logic              pslverr,
  input  logic              rx_valid,
  input  logic [BYTE_W-1:0] rx_data,
  output logic              rx_ready,
  output logic              tx_valid,
  output logic [BYTE_W-1:0] tx_data,
  input  logic              tx_ready,
  output logic              irq
);

  // named internal events
  logic              access, rd_acc, wr_acc;
  logic [7:0]        ofs_low;
  reg_sel_e          sel;
  logic              data_rd, data_wr, ctrl_wr;
  logic              pop, rx_take, rx_store, tx_send;
  logic [CTRL_W-1:0] ctrl_q;
  logic [BYTE_W-1:0] fifo_dout;
  logic [CNT_W-1:0]  level;
  logic              fifo_full, fifo_empty;
  logic [31:0]       status_q;

  assign access  = psel && penable;
  assign rd_acc  = access && !pwrite;
  assign wr_acc  = access && pwrite;
  assign ofs_low = 8'(paddr);
  assign sel     = decode_offset(ofs_low);

  assign data_rd = rd_acc && (sel == SEL_DATA);
  assign data_wr = wr_acc && (sel == SEL_DATA);
  assign ctrl_wr = wr_acc && (sel == SEL_CTRL);

  assign pop      = data_rd && !fifo_empty;
  assign rx_ready = !fifo_full;
  assign rx_take  = rx_valid && rx_ready;
  assign rx_store = rx_take && ctrl_q[CB_RX_EN];

  assign tx_valid = data_wr && ctrl_q[CB_TX_EN];
  assign tx_data  = pwdata[BYTE_W-1:0];
  assign tx_send  = tx_valid && tx_ready;

  assign pready  = 1'b1;
  assign pslverr = 1'b0;

  assign status_q = status_word(32'(level), RX_DEPTH);

  uart_rx_fifo #(.DEPTH(RX_DEPTH), .W(BYTE_W)) rx_fifo_i (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (rx_store),
    .din   (rx_data),
    .pop   (pop),
    .dout  (fifo_dout),
    .level (level),
    .full  (fifo_full),
    .empty (fifo_empty)
  );

  uart_ctrl_reg #(.W(CTRL_W)) ctrl_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (ctrl_wr),
    .wdata  (pwdata[CTRL_W-1:0]),
    .ctrl_q (ctrl_q)
  );

  uart_irq_gen irq_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .rx_evt (rx_store),
    .tx_evt (tx_send),
    .rx_ie  (ctrl_q[CB_RX_IE]),
    .tx_ie  (ctrl_q[CB_TX_IE]),
    .irq    (irq)
  );

  always_comb begin
    prdata = '0;
    if (rd_acc) begin
      case (sel)
        SEL_DATA: prdata = 32'(fifo_dout);
        SEL_STAT: prdata = status_q;
        SEL_CTRL: prdata = control_word(ctrl_q, FIFO_AVAIL);
        default:  prdata = '0;
      endcase
    end
  end

  logic unused_ok;
  assign unused_ok = ^{pwdata[31:CTRL_W], paddr};

  assert_setup_inert_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (psel && !penable) |=> ($stable(ctrl_q) && $stable(level)));

  assert_rx_drop_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !ctrl_q[CB_RX_EN] && !pop) |=> level == $past(level));

  assert_empty_read_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (data_rd && fifo_empty) |-> (prdata == 32'h0));

  assert_tx_offsets_R6: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> (ofs_low == OFS_DATA || ofs_low == OFS_DATA_BYTE));

  assert_zero_region_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_acc && sel == SEL_ZERO) |=> ($stable(ctrl_q) && $stable(level)));

endmodule

// File: tb/uart_apb_regs_tb.sv
`timescale 1ns/1ps
module uart_apb_regs_tb_top;

  localparam int DEPTH = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [7:0]  paddr = '0;
  logic [31:0] pwdata = '0;
  logic [31:0] prdata;
  logic        pready, pslverr;
  logic        rx_valid = 1'b0;
  logic [7:0]  rx_data = '0;
  logic        rx_ready;
  logic        tx_valid;
  logic [7:0]  tx_data;
  logic        tx_ready = 1'b1;
  logic        irq;

  int checks = 0;
  int failures = 0;
  int proto_bad = 0;

  logic [31:0] rd_v;
  logic        irq_s, tv_s, rdy_s;
  logic [7:0]  td_s;
  logic [7:0]  model_q[$];

  always #4 clk = ~clk;

  uart_apb_regs #(.RX_DEPTH(DEPTH)) dut_i (
    .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pready(pready),
    .pslverr(pslverr), .rx_valid(rx_valid), .rx_data(rx_data),
    .rx_ready(rx_ready), .tx_valid(tx_valid), .tx_data(tx_data),
    .tx_ready(tx_ready), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // expected status from a level: bits 1,2 fixed, 0 nonempty, 8 half, 10 full
  function automatic logic [31:0] exp_status(int n);
    logic [31:0] v;
    v = 32'h6;
    if (n > 0)          v = v + 32'h1;
    if (2 * n >= DEPTH) v = v + 32'h100;
    if (n == DEPTH)     v = v + 32'h400;
    return v;
  endfunction

  task automatic apb_rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); psel = 1; penable = 0; pwrite = 0; paddr = a;
    @(negedge clk); penable = 1;
    #1; d = prdata;
    if (pready !== 1'b1 || pslverr !== 1'b0) proto_bad++;
    @(negedge clk); psel = 0; penable = 0; irq_s = irq;
  endtask

  task automatic apb_wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); psel = 1; penable = 0; pwrite = 1; paddr = a; pwdata = d;
    @(negedge clk); penable = 1;
    #1; tv_s = tx_valid; td_s = tx_data;
    if (pready !== 1'b1 || pslverr !== 1'b0) proto_bad++;
    @(negedge clk); psel = 0; penable = 0; pwrite = 0; irq_s = irq;
  endtask

  task automatic rx_push(input logic [7:0] b);
    @(negedge clk); rx_valid = 1; rx_data = b;
    #1; rdy_s = rx_ready;
    @(negedge clk); rx_valid = 0; irq_s = irq;
  endtask

  initial begin
    #(8 * 100000);
    failures++;
    $display("FAIL R2 watchdog actual=hung expected=finished");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1 reset state
    chk("R1 irq", 32'(irq), 0);
    chk("R1 rx_ready", 32'(rx_ready), 1);
    apb_rd(8'h04, rd_v); chk("R1 status", rd_v, 32'h6);
    apb_rd(8'h08, rd_v); chk("R1 control", rd_v, 32'h8000_0000);

    // R5 empty read
    apb_rd(8'h00, rd_v); chk("R5 empty data", rd_v, 0);
    apb_rd(8'h04, rd_v); chk("R5 status after empty read", rd_v, 32'h6);

    // R9 control replace, status read-only
    apb_wr(8'h08, 32'hFFFF_FFFF);
    apb_rd(8'h08, rd_v); chk("R9 control all ones", rd_v, 32'h8000_1FFF);
    apb_wr(8'h08, 32'h0000_0A50);
    apb_rd(8'h08, rd_v); chk("R9 control replace", rd_v, 32'h8000_0A50);
    apb_wr(8'h08, 32'h0);
    apb_wr(8'h04, 32'hFFFF_FFFF);
    apb_rd(8'h04, rd_v); chk("R9 status ignores write", rd_v, 32'h6);

    // R10 scaler and unmapped offsets
    apb_wr(8'h0C, 32'h1234_5678);
    apb_wr(8'h10, 32'h0000_0003);
    apb_rd(8'h0C, rd_v); chk("R10 scaler reads zero", rd_v, 0);
    for (int a = 1; a < 256; a++) begin
      if (a != 3 && a != 4 && a != 8) begin
        apb_rd(8'(a), rd_v);
        if (rd_v !== 0) chk("R10 unmapped offset", rd_v, 0);
      end
    end
    chk("R10 unmapped sweep done", 0, 0);
    apb_rd(8'h08, rd_v); chk("R10 control untouched", rd_v, 32'h8000_0000);

    // R2 setup-phase-only cycle has no effect
    @(negedge clk); psel = 1; penable = 0; pwrite = 1; paddr = 8'h08; pwdata = 32'h3;
    @(negedge clk); psel = 0; pwrite = 0;
    apb_rd(8'h08, rd_v); chk("R2 setup-only write inert", rd_v, 32'h8000_0000);

    // R3 receive disabled discards
    rx_push(8'h55);
    chk("R3 taken while disabled", 32'(rdy_s), 1);
    apb_rd(8'h04, rd_v); chk("R3 discarded byte", rd_v, 32'h6);

    // R11 / R3 fill sweep
    apb_wr(8'h08, 32'h1);
    for (int i = 0; i < DEPTH; i++) begin
      logic [7:0] b;
      b = 8'((i * 37 + 11) & 8'hFF);
      rx_push(b);
      model_q.push_back(b);
      chk("R3 accepted", 32'(rdy_s), 1);
      chk("R8 no irq without enable", 32'(irq_s), 0);
      apb_rd(8'h04, rd_v); chk("R11 status while filling", rd_v, exp_status(i + 1));
    end
    #1; chk("R11 rx_ready low when full", 32'(rx_ready), 0);
    rx_push(8'hEE);
    chk("R11 push refused", 32'(rdy_s), 0);
    apb_rd(8'h04, rd_v); chk("R11 still full", rd_v, exp_status(DEPTH));

    // R4 / R6 drain through both offsets
    for (int i = 0; i < DEPTH; i++) begin
      apb_rd((i % 2) ? 8'h03 : 8'h00, rd_v);
      chk((i % 2) ? "R6 alias read" : "R4 ordered read", rd_v, 32'(model_q.pop_front()));
      apb_rd(8'h04, rd_v); chk("R11 status while draining", rd_v, exp_status(DEPTH - 1 - i));
    end
    apb_rd(8'h03, rd_v); chk("R5 empty read via alias", rd_v, 0);
    #1; chk("R11 rx_ready after drain", 32'(rx_ready), 1);

    // R8 receive interrupt
    apb_wr(8'h08, 32'h5);
    rx_push(8'h42); chk("R8 rx irq pulse", 32'(irq_s), 1);
    @(negedge clk); chk("R8 pulse one cycle", 32'(irq), 0);
    apb_rd(8'h00, rd_v); chk("R4 single byte", rd_v, 32'h42);
    chk("R8 no irq on read", 32'(irq_s), 0);
    apb_wr(8'h08, 32'h4);
    rx_push(8'h99); chk("R8 no irq when rx disabled", 32'(irq_s), 0);
    apb_rd(8'h04, rd_v); chk("R3 disabled leaves empty", rd_v, 32'h6);

    // R7 transmit
    apb_wr(8'h08, 32'h0);
    apb_wr(8'h00, 32'h1A5); chk("R7 no send when disabled", 32'(tv_s), 0);
    apb_wr(8'h08, 32'h2);
    apb_wr(8'h00, 32'h1A5);
    chk("R7 send valid", 32'(tv_s), 1);
    chk("R7 send data", 32'(td_s), 32'hA5);
    chk("R8 no tx irq without enable", 32'(irq_s), 0);
    apb_wr(8'h08, 32'hA);
    apb_wr(8'h03, 32'hFF3C);
    chk("R6 alias write valid", 32'(tv_s), 1);
    chk("R6 alias write data", 32'(td_s), 32'h3C);
    chk("R8 tx irq pulse", 32'(irq_s), 1);
    @(negedge clk); chk("R8 tx pulse one cycle", 32'(irq), 0);
    tx_ready = 0;
    apb_wr(8'h00, 32'h77);
    chk("R7 valid without ready", 32'(tv_s), 1);
    chk("R7 no completion no irq", 32'(irq_s), 0);
    tx_ready = 1;
    apb_wr(8'h04, 32'h11); chk("R7 no send on status write", 32'(tv_s), 0);

    chk("R2 pready/pslverr every access", proto_bad, 0);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule